// File: doc/BRIEF.md
# Partial Store Byte-Merge Unit

This unit forms the memory write for big-endian left and right partial stores, in word (32-bit) and doubleword (64-bit) sizes. A store of this kind places some bytes of a source register into an aligned memory container. Which bytes move, and where they land, depends on the low bits of the effective address. The unit receives the old container contents and combines them with the shifted register bytes under an address-derived mask. It returns the merged container, the aligned write address, a write strobe and a per-byte enable vector, so the result can go to a read-modify-write path or to a byte-masked memory.

A request is a single-cycle `req_valid` pulse. It carries the translated address, the source register, the old aligned data, the operation select and a translation-fault flag. One cycle later the unit either pulses `wr_strobe` with the merged result, or raises `store_exc` for one cycle and does not write. The memory, the cache and address translation sit outside the unit.

Top module: `partial_store_merge`

## Requirements
- R1: `wr_addr` is `req_addr` with its low 2 bits cleared for word operations and its low 3 bits cleared for doubleword operations. All higher bits pass through unchanged.
- R2: The operation encoding is 00 word-left, 01 word-right, 10 doubleword-left and 11 doubleword-right. Word-left with k = addr[1:0] uses shift s = 8k and mask M = 32'hFFFFFFFF >> s. It writes `wr_data` = {32'h0, (old[31:0] & ~M) | (reg[31:0] >> s)}.
- R3: Word-right with k = addr[1:0] uses shift s = 8(k XOR 3) and mask M = 32'hFFFFFFFF << s (kept to 32 bits). It writes `wr_data` = {32'h0, (old[31:0] & ~M) | ((reg[31:0] << s) & M)}.
- R4: Doubleword-left with k = addr[2:0] uses shift s = 8k and mask M = all-ones(64) >> s. It writes `wr_data` = (old & ~M) | (reg >> s).
- R5: Doubleword-right with k = addr[2:0] uses shift s = 8(k XOR 7) and mask M = all-ones(64) << s. It writes `wr_data` = (old & ~M) | (reg << s).
- R6: Word operations ignore bits 63:32 of `req_reg` and bits 63:32 of `req_old`.
- R7: While `wr_strobe` is high, bit i of `wr_byte_en` is set exactly when byte lane i (bits 8i+7..8i) lies inside the mask. For word operations bits 7:4 are zero. While `wr_strobe` is low, `wr_byte_en` is zero.
- R8: Each request with `req_fault` low produces `wr_strobe` high for exactly one cycle, in the cycle after `req_valid`. Back-to-back requests produce back-to-back strobes. With no request, the strobe stays low.
- R9: A request with `req_fault` high raises `store_exc` for exactly one cycle, in the cycle after `req_valid`. In that cycle `wr_strobe` is low and `wr_byte_en` is zero.
- R10: While reset is active and after reset, before any request, `wr_strobe`, `store_exc`, `wr_byte_en`, `wr_data` and `wr_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Single-cycle request strobe |
| req_op | input | 2 | Operation select (see R2) |
| req_addr | input | 64 | Translated effective address |
| req_reg | input | 64 | Source register value |
| req_old | input | 64 | Old aligned memory contents (low 32 bits for word operations) |
| req_fault | input | 1 | Address translation failed for this request |
| wr_strobe | output | 1 | One-cycle write command |
| wr_addr | output | 64 | Aligned write address |
| wr_data | output | 64 | Merged container data |
| wr_byte_en | output | 8 | Byte lanes actually rewritten |
| store_exc | output | 1 | One-cycle store address exception |

## Verification
The embedded assertions watch the handshake on every cycle. They check that the strobe and the exception are never high together, and that each one traces back to a request of the matching fault state one cycle earlier. They also check that the byte enables are empty when no write is issued and never empty when one is, that word writes never enable the upper four lanes, and that every strobed address is aligned. Only the bench scenarios can show that the merged bytes are correct. The bench sweeps every operation at every address offset with several register and memory patterns, computes the expected containers lane by lane from the big-endian byte placement, and drives fault, back-to-back and idle sequences.

// File: rtl/psm_pkg.sv
package psm_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    OP_WORD_LEFT   = 2'b00,
    OP_WORD_RIGHT  = 2'b01,
    OP_DWORD_LEFT  = 2'b10,
    OP_DWORD_RIGHT = 2'b11
  } psm_op_e;

  function automatic logic op_is_dword(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic op_is_right(input logic [1:0] op);
    return op[0];
  endfunction
endpackage

// File: rtl/psm_mask_gen.sv
module psm_mask_gen
  import psm_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned OFS_W = $clog2(LANES),
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [1:0]        op,
  input  logic [OFS_W-1:0]  ofs,
  output logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] mask,
  output logic [LANES-1:0]  byte_en
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [OFS_W-1:0]  idx;
  logic [OFS_W-1:0]  sel;
  logic [DATA_W-1:0] full;

  always_comb begin
    if (op_is_dword(op)) begin
      idx  = ofs;
      full = '1;
    end else begin
      idx  = {1'b0, ofs[OFS_W-2:0]};
      full = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
    end
    // right forms count from the opposite end of the container
    if (op_is_right(op)) begin
      sel = op_is_dword(op) ? ~idx : {1'b0, ~idx[OFS_W-2:0]};
    end else begin
      sel = idx;
    end
    shamt = SH_W'(sel) << $clog2(LANE_W);
    if (op_is_right(op)) mask = (full << shamt) & full;
    else                 mask = full >> shamt;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_en
    assign byte_en[g] = mask[g*LANE_W];
  end
endmodule

// File: rtl/psm_merge.sv
module psm_merge
  import psm_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned SH_W = $clog2(DATA_W)
) (
  input  logic [1:0]        op,
  input  logic [SH_W-1:0]   shamt,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] reg_data,
  input  logic [DATA_W-1:0] old_data,
  output logic [DATA_W-1:0] merged
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    if (op_is_dword(op)) begin
      src  = reg_data;
      base = old_data;
    end else begin
      src  = {{HALF_W{1'b0}}, reg_data[HALF_W-1:0]};
      base = {{HALF_W{1'b0}}, old_data[HALF_W-1:0]};
    end
    shifted = op_is_right(op) ? (src << shamt) : (src >> shamt);
    merged  = (base & ~mask) | (shifted & mask);
  end
endmodule

// File: rtl/partial_store_merge.sv
module partial_store_merge
  import psm_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned LANES = DATA_W / LANE_W,
  localparam int unsigned OFS_W = $clog2(LANES),
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_old,
  input  logic              req_fault,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_byte_en,
  output logic              store_exc
);
  localparam int unsigned HALF_LANES = LANES / 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic [SH_W-1:0]   shamt;
  logic [DATA_W-1:0] mask;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] merged;

  psm_mask_gen #(.DATA_W(DATA_W)) u_mask_gen (
    .op      (req_op),
    .ofs     (req_addr[OFS_W-1:0]),
    .shamt   (shamt),
    .mask    (mask),
    .byte_en (lane_en)
  );

  psm_merge #(.DATA_W(DATA_W)) u_merge (
    .op       (req_op),
    .shamt    (shamt),
    .mask     (mask),
    .reg_data (req_reg),
    .old_data (req_old),
    .merged   (merged)
  );

  // next state
  logic              do_write;
  logic              do_exc;
  logic              addr_en;
  logic              data_en;
  logic [ADDR_W-1:0] addr_d;
  logic [LANES-1:0]  be_d;

  always_comb begin
    do_write = req_valid && !req_fault;
    do_exc   = req_valid && req_fault;
    addr_en  = req_valid;
    data_en  = do_write;
    addr_d   = req_addr;
    if (op_is_dword(req_op)) addr_d[OFS_W-1:0] = '0;
    else                     addr_d[OFS_W-2:0] = '0;
    be_d = do_write ? lane_en : '0;
  end

  // registers
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      wr_strobe  <= 1'b0;
      store_exc  <= 1'b0;
      wr_byte_en <= '0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_strobe  <= do_write;
      store_exc  <= do_exc;
      wr_byte_en <= be_d;
      if (addr_en) wr_addr <= addr_d;
      if (data_en) wr_data <= merged;
    end
  end

  // checks
  assert_strobe_exc_excl_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(wr_strobe && store_exc));

  assert_strobe_source_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    wr_strobe |-> $past(req_valid && !req_fault));

  assert_exc_source_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    store_exc |-> $past(req_valid && req_fault));

  assert_be_idle_zero_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    !wr_strobe |-> (wr_byte_en == '0));

  assert_be_nonempty_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    wr_strobe |-> (wr_byte_en != '0));

  assert_word_upper_lanes_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_strobe && !$past(req_op[1])) |-> (wr_byte_en[LANES-1:HALF_LANES] == '0));

  assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    wr_strobe |-> (wr_addr[OFS_W-2:0] == '0));
endmodule

// File: tb/partial_store_merge_bench.sv
module partial_store_merge_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [63:0] req_addr;
  logic [63:0] req_reg;
  logic [63:0] req_old;
  logic        req_fault;
  logic        wr_strobe;
  logic [63:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_byte_en;
  logic        store_exc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  partial_store_merge u_partial_store_merge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_reg(req_reg), .req_old(req_old),
    .req_fault(req_fault), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_byte_en(wr_byte_en), .store_exc(store_exc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result built lane by lane from big-endian byte placement
  task automatic model(input logic [1:0] op, input logic [63:0] addr,
                       input logic [63:0] rv, input logic [63:0] ov,
                       output logic [63:0] d, output logic [7:0] be,
                       output logic [63:0] a);
    int nb = op[1] ? 8 : 4;
    int k  = int'(addr[2:0]) % nb;
    d  = op[1] ? ov : {32'h0, ov[31:0]};
    be = '0;
    for (int j = 0; j < nb; j++) begin
      int lane = nb - 1 - j;
      int src  = -1;
      if (!op[0] && j >= k) src = nb - 1 - (j - k);
      if (op[0] && j <= k)  src = k - j;
      if (src >= 0) begin
        d[lane*8 +: 8] = rv[src*8 +: 8];
        be[lane] = 1'b1;
      end
    end
    a = addr & ~64'(nb - 1);
  endtask

  task automatic issue(input logic [1:0] op, input logic [63:0] addr,
                       input logic [63:0] rv, input logic [63:0] ov, input logic flt);
    req_valid = 1'b1; req_op = op; req_addr = addr;
    req_reg = rv; req_old = ov; req_fault = flt;
  endtask

  task automatic idle_in();
    req_valid = 1'b0; req_fault = 1'b0;
  endtask

  task automatic check_write(input logic [1:0] op, input logic [63:0] addr,
                             input logic [63:0] rv, input logic [63:0] ov);
    logic [63:0] d, a;
    logic [7:0]  be;
    string rq;
    model(op, addr, rv, ov, d, be, a);
    case (op)
      2'b00: rq = "R2/R6 word-left";
      2'b01: rq = "R3/R6 word-right";
      2'b10: rq = "R4 dword-left";
      default: rq = "R5 dword-right";
    endcase
    chk($sformatf("%s data ofs=%0d", rq, addr[2:0]), wr_data, d);
    chk($sformatf("R7 byte_en op=%0d ofs=%0d", op, addr[2:0]), {56'h0, wr_byte_en}, {56'h0, be});
    chk($sformatf("R1 addr op=%0d ofs=%0d", op, addr[2:0]), wr_addr, a);
    chk("R8 strobe after valid", {63'h0, wr_strobe}, 64'h1);
    chk("R9 no exc on clean request", {63'h0, store_exc}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_in();
    req_op = 2'b00; req_addr = '0; req_reg = '0; req_old = '0;
    repeat (3) @(negedge clk);
    // R10 during reset
    chk("R10 strobe in reset", {63'h0, wr_strobe}, 64'h0);
    chk("R10 exc in reset", {63'h0, store_exc}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 strobe after reset", {63'h0, wr_strobe}, 64'h0);
    chk("R10 exc after reset", {63'h0, store_exc}, 64'h0);
    chk("R10 byte_en after reset", {56'h0, wr_byte_en}, 64'h0);
    chk("R10 data after reset", wr_data, 64'h0);
    chk("R10 addr after reset", wr_addr, 64'h0);

    // full sweep: every op, every offset, several patterns
    for (int p = 0; p < 3; p++) begin
      for (int op = 0; op < 4; op++) begin
        for (int ofs = 0; ofs < 8; ofs++) begin
          logic [63:0] rv = 64'h0102030405060708 ^ (64'(p) * 64'hF0E1D2C3B4A59687);
          logic [63:0] ov = 64'hA0A1A2A3A4A5A6A7 ^ (64'(p) * 64'h1111111111111111);
          logic [63:0] ad = {48'hBEEF_0000_1234 + 48'(p), 13'(op * 8 + ofs), 3'(ofs)};
          @(negedge clk);
          issue(2'(op), ad, rv, ov, 1'b0);
          @(negedge clk);
          idle_in();
          check_write(2'(op), ad, rv, ov);
        end
      end
    end

    // R6: word-left with upper register and old halves altered gives same low bytes
    @(negedge clk);
    issue(2'b00, 64'h100, 64'hFFFFFFFF_11223344, 64'hEEEEEEEE_55667788, 1'b0);
    @(negedge clk);
    idle_in();
    chk("R6 word ignores upper halves", wr_data, 64'h00000000_11223344);

    // R8: idle cycle after a write drops the strobe
    @(negedge clk);
    chk("R8 single strobe pulse", {63'h0, wr_strobe}, 64'h0);
    chk("R7 byte_en zero when idle", {56'h0, wr_byte_en}, 64'h0);

    // R9: faulting request
    @(negedge clk);
    issue(2'b11, 64'h2005, 64'h1, 64'h2, 1'b1);
    @(negedge clk);
    idle_in();
    chk("R9 exc raised", {63'h0, store_exc}, 64'h1);
    chk("R9 strobe suppressed", {63'h0, wr_strobe}, 64'h0);
    chk("R9 byte_en zero", {56'h0, wr_byte_en}, 64'h0);
    @(negedge clk);
    chk("R9 exc single cycle", {63'h0, store_exc}, 64'h0);

    // R8: back-to-back requests
    @(negedge clk);
    issue(2'b10, 64'h3003, 64'h8877665544332211, 64'h0, 1'b0);
    @(negedge clk);
    check_write(2'b10, 64'h3003, 64'h8877665544332211, 64'h0);
    issue(2'b01, 64'h4001, 64'h0000000099AABBCC, 64'hFFFFFFFF, 1'b0);
    @(negedge clk);
    idle_in();
    check_write(2'b01, 64'h4001, 64'h0000000099AABBCC, 64'hFFFFFFFF);
    @(negedge clk);
    chk("R8 strobe low after burst", {63'h0, wr_strobe}, 64'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule